// File: doc/BRIEF.md
# Re-encoding channel error rate monitor

This block estimates the raw bit error rate of a channel that feeds a convolutional decoder. Each decoded bit is passed through a local copy of the rate-1/2 mother encoder (constraint length 7). The resulting symbol pair is thinned by the puncturing pattern of the active code rate. Each surviving bit is compared with the hard-decision channel bit received for the same position. Since the decoder has usually corrected most channel errors, a mismatch marks a bit that the channel got wrong.

Channel symbol pairs are queued in a small FIFO until the matching decoded bit arrives, so the decoder latency is absorbed automatically. Mismatches are counted over a window whose length the host sets in units of four compared bits. When a window ends, the count is copied into a result register that host reads leave untouched. A sticky status bit is also set, and it can drive an interrupt line.

Top module: `reenc_ber_mon`

## Requirements
- R1: After reset, all eight register addresses read 0x00 and `irq` is low.
- R2: The re-encoder forms X = d(n)^d(n-1)^d(n-2)^d(n-3)^d(n-6) (taps 171 octal) and Y = d(n)^d(n-2)^d(n-3)^d(n-5)^d(n-6) (taps 133 octal). Its history starts at zero after reset. Channel pairs carry X on `ch_pair[1]` and Y on `ch_pair[0]`.
- R3: `rate_sel` codes 0..5 select rates 1/2, 2/3, 3/4, 5/6, 6/7 and 7/8. The per-step keep patterns, listed from phase 0, are as follows. Rate 1/2 keeps both bits on every step. Rate 2/3 uses X 10, Y 11. Rate 3/4 uses X 101, Y 110. Rate 5/6 uses X 10101, Y 11010. Rate 6/7 uses X 100101, Y 111010. Rate 7/8 uses X 1000101, Y 1111010. Codes 6 and 7 act as rate 1/2. A punctured bit is never compared or counted.
- R4: Channel pairs are paired with decoded bits in arrival order. A `dec_valid` pulse that arrives while no channel pair is queued is ignored.
- R5: A window of period P (P != 0) closes on the step where the number of bits compared in it reaches or passes 4*P. With P = 0 no window ever closes.
- R6: On close, the error count of the window, including that step's errors, is latched into the result register, and counting restarts from zero.
- R7: Reading never changes the result register. It changes only when a window closes.
- R8: A close sets status bit 2 at address 7. Writing 1 to that bit clears it, and writing 0 leaves it set. `irq` is high exactly when the status bit and enable bit 2 at address 6 are both set.
- R9: Writing any period byte discards the partial window (bit and error counts) and returns the puncturing phase to 0.
- R10: The register map is: addresses 0/1/2 hold period bits 23:16, 15:8 and 7:0 (read/write); addresses 3/4/5 hold result bits 23:16, 15:8 and 7:0 (read only); address 6 holds the enable; address 7 holds the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 3 | Code rate select |
| ch_valid | input | 1 | Channel pair strobe |
| ch_pair | input | 2 | Hard channel bits {X, Y} |
| dec_valid | input | 1 | Decoded bit strobe |
| dec_bit | input | 1 | Decoded bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
A decoded bit that closes a window updates the result bytes and the status bit at the same rising edge that samples `dec_valid`, and `irq` follows from those registers without further delay. The bench therefore drives each strobe at a falling edge and releases it at the next falling edge. It reads registers one nanosecond after a falling edge, which puts every sample half a cycle after the edge that made the change. A read is combinational, so the register map is observed without any added cycle. Boundary checks sample just before and just after the closing step.

// File: rtl/reenc_pkg.sv
package reenc_pkg;

  localparam int VAL_W = 24;
  localparam int PH_W  = 3;

  typedef enum logic [2:0] {
    RATE_1_2 = 3'd0,
    RATE_2_3 = 3'd1,
    RATE_3_4 = 3'd2,
    RATE_5_6 = 3'd3,
    RATE_6_7 = 3'd4,
    RATE_7_8 = 3'd5
  } rate_e;

  function automatic logic [PH_W-1:0] punct_len(input logic [2:0] r);
    case (r)
      RATE_2_3: punct_len = 3'd2;
      RATE_3_4: punct_len = 3'd3;
      RATE_5_6: punct_len = 3'd5;
      RATE_6_7: punct_len = 3'd6;
      RATE_7_8: punct_len = 3'd7;
      default:  punct_len = 3'd1;
    endcase
  endfunction

  // bit k of each mask is phase k; returns {keep_x, keep_y}
  function automatic logic [1:0] punct_keep(input logic [2:0] r, input logic [PH_W-1:0] ph);
    logic [7:0] xm, ym;
    case (r)
      RATE_2_3: begin xm = 8'b0000_0001; ym = 8'b0000_0011; end
      RATE_3_4: begin xm = 8'b0000_0101; ym = 8'b0000_0011; end
      RATE_5_6: begin xm = 8'b0001_0101; ym = 8'b0000_1011; end
      RATE_6_7: begin xm = 8'b0010_1001; ym = 8'b0001_0111; end
      RATE_7_8: begin xm = 8'b0101_0001; ym = 8'b0010_1111; end
      default:  begin xm = 8'b1111_1111; ym = 8'b1111_1111; end
    endcase
    punct_keep = {xm[ph], ym[ph]};
  endfunction

endpackage

// File: rtl/reenc_conv_enc.sv
module reenc_conv_enc
  import reenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       restart,
  input  logic [2:0] rate,
  input  logic       dbit,
  output logic [1:0] pair,
  output logic [1:0] keep
);

  logic [5:0]      sr_q, sr_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic [PH_W-1:0] last_ph;

  assign last_ph = punct_len(rate) - 3'd1;
  // sr_q[0] holds d(n-1), sr_q[5] holds d(n-6)
  assign pair[1] = dbit ^ sr_q[0] ^ sr_q[1] ^ sr_q[2] ^ sr_q[5];
  assign pair[0] = dbit ^ sr_q[1] ^ sr_q[2] ^ sr_q[4] ^ sr_q[5];
  assign keep    = punct_keep(rate, ph_q);

  always_comb begin
    sr_d = sr_q;
    ph_d = ph_q;
    if (step) begin
      sr_d = {sr_q[4:0], dbit};
      ph_d = (ph_q >= last_ph) ? '0 : ph_q + 3'd1;
    end
    if (restart) ph_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      ph_q <= '0;
    end else begin
      sr_q <= sr_d;
      ph_q <= ph_d;
    end
  end

  a_r2_history_shift: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> sr_q[0] == $past(dbit));
  a_r3_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && ph_q == last_ph) |=> ph_q == '0);
  a_r9_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> ph_q == '0);

endmodule

// File: rtl/reenc_pair_fifo.sv
module reenc_pair_fifo #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [1:0] din,
  input  logic       pop,
  output logic [1:0] dout,
  output logic       empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0]    mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  a_r4_pop_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push) |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r4_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/reenc_err_window.sv
module reenc_err_window
  import reenc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             restart,
  input  logic [1:0]       nkeep,
  input  logic [1:0]       nerr,
  input  logic [VAL_W-1:0] period,
  output logic [VAL_W-1:0] result,
  output logic             done
);

  localparam int BW = VAL_W + 2;

  logic [BW-1:0]    bits_q, bits_d, bits_sum;
  logic [VAL_W-1:0] err_q, err_d, err_sat, res_q, res_d;
  logic [VAL_W:0]   err_sum;

  assign bits_sum = bits_q + {{VAL_W{1'b0}}, nkeep};
  assign err_sum  = {1'b0, err_q} + {{(VAL_W-1){1'b0}}, nerr};
  assign err_sat  = err_sum[VAL_W] ? '1 : err_sum[VAL_W-1:0];
  assign done     = step && !restart && (period != '0) && (bits_sum >= {period, 2'b00});
  assign result   = res_q;

  always_comb begin
    bits_d = bits_q;
    err_d  = err_q;
    res_d  = res_q;
    if (restart) begin
      bits_d = '0;
      err_d  = '0;
    end else if (done) begin
      res_d  = err_sat;
      bits_d = '0;
      err_d  = '0;
    end else if (step) begin
      if (period != '0) bits_d = bits_sum;
      err_d = err_sat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      err_q  <= '0;
      res_q  <= '0;
    end else begin
      bits_q <= bits_d;
      err_q  <= err_d;
      res_q  <= res_d;
    end
  end

  a_r6_restart_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (err_q == '0 && bits_q == '0));
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(res_q));
  a_r5_errors_within_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (period != '0) |-> ({2'b00, err_q} <= bits_q));
  a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> bits_q == '0);

endmodule

// File: rtl/reenc_ber_mon.sv
module reenc_ber_mon
  import reenc_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate_sel,
  input  logic       ch_valid,
  input  logic [1:0] ch_pair,
  input  logic       dec_valid,
  input  logic       dec_bit,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);

  localparam logic [2:0] A_EN   = 3'd6;
  localparam logic [2:0] A_STAT = 3'd7;

  logic             rs_q1, rs_q2, rst_i;
  logic [VAL_W-1:0] per_q, per_d, result;
  logic             en_q, en_d, stat_q, stat_d;
  logic             per_wr, step, fifo_empty, win_done;
  logic [1:0]       ch_head, enc_pair, keep, diff, nkeep, nerr;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_i = rs_q2;

  assign per_wr = reg_wr && (reg_addr <= 3'd2);
  assign step   = dec_valid && !fifo_empty;
  assign diff   = keep & (enc_pair ^ ch_head);
  assign nkeep  = {1'b0, keep[1]} + {1'b0, keep[0]};
  assign nerr   = {1'b0, diff[1]} + {1'b0, diff[0]};

  reenc_pair_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_i), .push(ch_valid), .din(ch_pair),
    .pop(dec_valid), .dout(ch_head), .empty(fifo_empty)
  );

  reenc_conv_enc u_enc (
    .clk(clk), .rst_n(rst_i), .step(step), .restart(per_wr),
    .rate(rate_sel), .dbit(dec_bit), .pair(enc_pair), .keep(keep)
  );

  reenc_err_window u_win (
    .clk(clk), .rst_n(rst_i), .step(step), .restart(per_wr),
    .nkeep(nkeep), .nerr(nerr), .period(per_q), .result(result), .done(win_done)
  );

  always_comb begin
    per_d  = per_q;
    en_d   = en_q;
    stat_d = stat_q;
    if (reg_wr) begin
      case (reg_addr)
        3'd0:    per_d[23:16] = reg_wdata;
        3'd1:    per_d[15:8]  = reg_wdata;
        3'd2:    per_d[7:0]   = reg_wdata;
        A_EN:    en_d         = reg_wdata[2];
        A_STAT:  if (reg_wdata[2]) stat_d = 1'b0;
        default: ;
      endcase
    end
    if (win_done) stat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      per_q  <= '0;
      en_q   <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      per_q  <= per_d;
      en_q   <= en_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = per_q[23:16];
      3'd1:    reg_rdata = per_q[15:8];
      3'd2:    reg_rdata = per_q[7:0];
      3'd3:    reg_rdata = result[23:16];
      3'd4:    reg_rdata = result[15:8];
      3'd5:    reg_rdata = result[7:0];
      A_EN:    reg_rdata = {5'd0, en_q, 2'd0};
      default: reg_rdata = {5'd0, stat_q, 2'd0};
    endcase
  end

  assign irq = stat_q && en_q;

  a_r8_irq_on_close: assert property (@(posedge clk) disable iff (!rst_i)
    (win_done && en_q && !(reg_wr && reg_addr == A_EN)) |=> irq);
  a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_i)
    (reg_wr && reg_addr == A_STAT && reg_wdata[2] && !win_done) |=> !irq);
  a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_i)
    (stat_q && !(reg_wr && reg_addr == A_STAT)) |=> stat_q);

endmodule

// File: tb/reenc_ber_mon_test.sv
module reenc_ber_mon_test;

  localparam int CLK_PERIOD = 10;
  localparam int MAXV = 24'hFF_FFFF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic       ch_valid = 1'b0;
  logic [1:0] ch_pair = 2'b00;
  logic       dec_valid = 1'b0;
  logic       dec_bit = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq;

  reenc_ber_mon uut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .ch_valid(ch_valid),
    .ch_pair(ch_pair), .dec_valid(dec_valid), .dec_bit(dec_bit),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  // bench model
  string xpat[6] = '{"1", "10", "101", "10101", "100101", "1000101"};
  string ypat[6] = '{"1", "11", "110", "11010", "111010", "1111010"};
  logic [5:0] gen_h = '0, mdl_h = '0;
  logic [15:0] lfsr = 16'hACE1;
  int m_per = 0, m_bits = 0, m_err = 0, m_res = 0, m_phase = 0;
  bit m_stat = 0, m_en = 0;
  bit dq[$];
  logic [1:0] cq[$];

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] encode(input logic [5:0] h, input bit b);
    logic x, y;
    x = b ^ h[0] ^ h[1] ^ h[2] ^ h[5];
    y = b ^ h[1] ^ h[2] ^ h[4] ^ h[5];
    return {x, y};
  endfunction

  function automatic bit nextrand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a <= 3'd2) begin
      case (a)
        3'd0: m_per = (m_per & 32'h0000_FFFF) | (int'(d) << 16);
        3'd1: m_per = (m_per & 32'h00FF_00FF) | (int'(d) << 8);
        default: m_per = (m_per & 32'h00FF_FF00) | int'(d);
      endcase
      m_bits = 0; m_err = 0; m_phase = 0;
    end
    if (a == 3'd6) m_en = d[2];
    if (a == 3'd7 && d[2]) m_stat = 0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic read_result(output int v);
    logic [7:0] h, m, l;
    reg_read(3'd3, h); reg_read(3'd4, m); reg_read(3'd5, l);
    v = int'({h, m, l});
  endtask

  task automatic set_period(input int p);
    reg_write(3'd0, p[23:16]); reg_write(3'd1, p[15:8]); reg_write(3'd2, p[7:0]);
  endtask

  // mode 0 clean, 1 flip both, 2 random flips, 3 flip X only
  task automatic push_ch(input int mode);
    bit b;
    logic [1:0] c;
    b = nextrand();
    c = encode(gen_h, b);
    gen_h = {gen_h[4:0], b};
    case (mode)
      1: c = ~c;
      2: c = c ^ {nextrand(), nextrand()};
      3: c = c ^ 2'b10;
      default: ;
    endcase
    dq.push_back(b); cq.push_back(c);
    @(negedge clk);
    ch_valid = 1'b1; ch_pair = c;
    @(negedge clk);
    ch_valid = 1'b0;
  endtask

  task automatic pop_dec();
    bit b;
    logic [1:0] c, e, k, df;
    int r, len, nk, ne;
    b = dq.pop_front(); c = cq.pop_front();
    @(negedge clk);
    dec_valid = 1'b1; dec_bit = b;
    @(negedge clk);
    dec_valid = 1'b0;
    r = (int'(rate_sel) > 5) ? 0 : int'(rate_sel);
    len = xpat[r].len();
    k = {xpat[r][m_phase] == "1", ypat[r][m_phase] == "1"};
    e = encode(mdl_h, b);
    mdl_h = {mdl_h[4:0], b};
    df = k & (e ^ c);
    nk = int'(k[1]) + int'(k[0]);
    ne = int'(df[1]) + int'(df[0]);
    m_phase = (m_phase == len - 1) ? 0 : m_phase + 1;
    if (m_per != 0 && m_bits + nk >= 4 * m_per) begin
      m_res = (m_err + ne > MAXV) ? MAXV : m_err + ne;
      m_err = 0; m_bits = 0; m_stat = 1;
    end else begin
      if (m_per != 0) m_bits += nk;
      m_err = (m_err + ne > MAXV) ? MAXV : m_err + ne;
    end
  endtask

  task automatic step(input int mode);
    push_ch(mode);
    pop_dec();
  endtask

  task automatic check_state(string req);
    int v;
    logic [7:0] s;
    read_result(v);
    chk({req, " result"}, v, m_res);
    reg_read(3'd7, s);
    chk({req, " status"}, int'(s[2]), int'(m_stat));
    chk({req, " irq"}, int'(irq), int'(m_stat & m_en));
  endtask

  // R1 reset state, R10 addresses
  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      reg_read(3'(a), d);
      chk("R1 register reset value", int'(d), 0);
    end
    chk("R1 irq low after reset", int'(irq), 0);
  endtask

  task automatic t_map();
    logic [7:0] d;
    set_period(24'h12_34_56);
    reg_read(3'd0, d); chk("R10 period high byte", int'(d), 8'h12);
    reg_read(3'd1, d); chk("R10 period mid byte", int'(d), 8'h34);
    reg_read(3'd2, d); chk("R10 period low byte", int'(d), 8'h56);
    reg_write(3'd3, 8'hFF);
    reg_read(3'd3, d); chk("R10 result is read only", int'(d), 0);
  endtask

  // R2 R5: clean rate 1/2, window 16 bits = 8 steps
  task automatic t_clean_boundary();
    rate_sel = 3'd0;
    set_period(4);
    for (int i = 0; i < 7; i++) step(0);
    check_state("R5 before last step");
    chk("R5 no close at 14 of 16 bits", int'(m_stat), 0);
    step(0);
    check_state("R2 clean window");
    chk("R5 closes at 16 bits", int'(m_stat), 1);
    chk("R2 clean stream counts zero", m_res, 0);
  endtask

  // R6: all bits flipped at rate 1/2
  task automatic t_flip_half();
    reg_write(3'd7, 8'h04);
    for (int i = 0; i < 8; i++) step(1);
    check_state("R6 flipped window");
    chk("R6 sixteen errors latched", m_res, 16);
    step(1);
    check_state("R6 next window starts at zero");
  endtask

  // R3: every rate, flip both bits then random
  task automatic t_rates();
    for (int r = 0; r < 6; r++) begin
      rate_sel = 3'(r);
      set_period(3);
      reg_write(3'd7, 8'h04);
      for (int i = 0; i < 30 && !m_stat; i++) step(1);
      check_state("R3 rate flip-all");
      chk("R3 only kept bits counted", (m_res == 12 || m_res == 13) ? 1 : 0, 1);
      reg_write(3'd7, 8'h04);
      for (int i = 0; i < 30 && !m_stat; i++) step(2);
      check_state("R3 rate random flips");
      reg_write(3'd7, 8'h04);
      for (int i = 0; i < 30 && !m_stat; i++) step(3);
      check_state("R3 rate X-only flips");
    end
    rate_sel = 3'd7;
    set_period(2);
    reg_write(3'd7, 8'h04);
    for (int i = 0; i < 4; i++) step(1);
    check_state("R3 code 7 acts as rate 1/2");
    chk("R3 code 7 eight errors", m_res, 8);
  endtask

  // R7: reads do not clear, partial window does not alter result
  task automatic t_hold();
    int a, b;
    rate_sel = 3'd0;
    set_period(3);
    for (int i = 0; i < 6; i++) step(1);
    read_result(a);
    read_result(b);
    chk("R7 second read equals first", b, a);
    step(1); step(1);
    read_result(b);
    chk("R7 result held mid window", b, 12);
  endtask

  // R8 interrupt gating and write-one-to-clear
  task automatic t_irq();
    logic [7:0] s;
    reg_write(3'd6, 8'h00);
    chk("R8 irq masked", int'(irq), 0);
    reg_read(3'd7, s);
    chk("R8 status still set", int'(s[2]), 1);
    reg_write(3'd6, 8'h04);
    chk("R8 irq when enabled", int'(irq), 1);
    reg_write(3'd7, 8'h00);
    chk("R8 writing zero keeps status", int'(irq), 1);
    reg_write(3'd7, 8'h04);
    chk("R8 write one clears", int'(irq), 0);
  endtask

  // R9: period write discards partial window and puncture phase
  task automatic t_restart();
    rate_sel = 3'd0;
    set_period(4);
    reg_write(3'd7, 8'h04);
    for (int i = 0; i < 5; i++) step(1);
    set_period(4);
    for (int i = 0; i < 8; i++) step(0);
    check_state("R9 restart window");
    chk("R9 partial errors discarded", m_res, 0);
    rate_sel = 3'd2;
    step(3);
    set_period(1);
    reg_write(3'd7, 8'h04);
    for (int i = 0; i < 3; i++) step(3);
    check_state("R9 phase back to zero");
    chk("R9 X flips seen at phases 0 and 2", m_res, 2);
  endtask

  // R4: burst ordering and ignored strobe on empty queue
  task automatic t_fifo();
    rate_sel = 3'd0;
    set_period(5);
    reg_write(3'd7, 8'h04);
    @(negedge clk); dec_valid = 1'b1; dec_bit = 1'b1;
    @(negedge clk); dec_valid = 1'b0;
    for (int i = 0; i < 10; i++) push_ch(2);
    for (int i = 0; i < 10; i++) pop_dec();
    check_state("R4 burst ordering");
    chk("R4 window closed after burst", int'(m_stat), 1);
  endtask

  // R5: period zero never closes
  task automatic t_zero_period();
    set_period(0);
    reg_write(3'd7, 8'h04);
    for (int i = 0; i < 20; i++) step(1);
    check_state("R5 period zero");
    chk("R5 period zero no close", int'(m_stat), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_map();
    t_clean_boundary();
    t_flip_half();
    t_rates();
    t_hold();
    t_irq();
    t_restart();
    t_fifo();
    t_zero_period();
    done_flag = 1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

endmodule